// File: doc/BRIEF.md
# Clock Failure Supervisor Register

This block supervises two clock sources against an always-running reference clock: an external oscillator input and a PLL lock indication. An external clock that stops toggling, or a PLL that drops out of lock, sets a sticky status flag. Any flag whose monitor is enabled drives a non-maskable interrupt request. The interrupt stays high until software clears the flag. The block takes no part in switching the system clock to a backup source.

Software sees one 8-bit control and status register. Each flag is cleared by writing a one to it. Each monitor enable can only be set during a short protected window that opens when the unlock input pulses. Once set, an enable cannot be cleared by software and only a reset clears it. The bus port runs on the reference clock. Writes take effect at the clock edge where `wr_en` is sampled high, and `rd_data` always shows the current register contents.

Top module: `clkmon_top`

## Requirements
- R1: Register bits 7 to 4 always read as zero, and writing ones to them changes nothing.
- R2: Bit 3 is the PLL fault flag and bit 2 is its enable. With bit 2 set, a high-to-low transition of the two-flop synchronised `pll_locked` sets bit 3. The flag is set by the third reference edge after the input falls.
- R3: Writing a one to bit 1 or bit 3 clears that flag. Writing a zero to a flag, or writing a one to a flag that is already clear, leaves it unchanged.
- R4: Bit 1 is the oscillator failure flag and bit 0 is its enable. With bit 0 set, bit 1 is set after TIMEOUT consecutive reference cycles in which no synchronised rising edge of `ext_clk` is seen. If the clock is still dead after the flag is cleared, the flag is set again. A toggling clock never sets the flag. With the enable clear, no flag is ever set.
- R5: A write can set bit 0 or bit 2 only if it is sampled on one of the WINDOW reference edges that follow the edge on which `unlock` was sampled high. At any other time, writes to these bits are ignored.
- R6: Once bit 0 or bit 2 is set, no write clears it. Only reset clears it.
- R7: After reset the register reads 0x00 and `nmi` is low.
- R8: If a failure event and a one-write to the same flag bit occur on the same edge, the flag ends up set.
- R9: `nmi` is high exactly when (bit 1 AND bit 0) OR (bit 3 AND bit 2). It stays high until every contributing flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock; also the register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| ext_clk | input | 1 | External oscillator clock under supervision |
| pll_locked | input | 1 | PLL lock indication (asynchronous) |
| unlock | input | 1 | Pulse that opens the protected-write window |
| nmi | output | 1 | Non-maskable interrupt request |

## Verification
The bench uses the default parameters: TIMEOUT of 32 cycles, WINDOW of 4 edges and two synchroniser stages. With a 32-cycle timeout, a dead oscillator is flagged within about forty reference cycles. This leaves room to show repeated detection after a clear. A toggling external clock with a 4-cycle period shows that the counter restarts on every edge. The 4-edge window is short enough to test both its last allowed edge and the first refused edge. The two-stage synchroniser puts the PLL loss event on a known edge. That lets the bench drive a flag-clear write on exactly that edge to test the set-wins rule.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Bit positions inside the 8-bit control/status register
  localparam int BIT_OSC_EN   = 0;
  localparam int BIT_OSC_FLAG = 1;
  localparam int BIT_PLL_EN   = 2;
  localparam int BIT_PLL_FLAG = 3;
  localparam int REG_W        = 8;

  typedef struct packed {
    logic pll_flag;  // bit 3
    logic pll_en;    // bit 2
    logic osc_flag;  // bit 1
    logic osc_en;    // bit 0
  } ctl_t;

  // Sticky flag update: a hardware event beats a software clear
  function automatic logic flag_next(logic cur, logic evt, logic clr);
    return evt | (cur & ~clr);
  endfunction

  // Write-once enable: only ever goes from 0 to 1
  function automatic logic en_next(logic cur, logic set_req);
    return cur | set_req;
  endfunction

  // Read view with reserved upper nibble forced to zero
  function automatic logic [REG_W-1:0] pack_view(ctl_t c);
    return {4'b0000, c};
  endfunction

  // Interrupt request from the register contents
  function automatic logic nmi_of(ctl_t c);
    return (c.osc_flag & c.osc_en) | (c.pll_flag & c.pll_en);
  endfunction

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_osc_watch.sv
module clkmon_osc_watch #(
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ext_clk,
  output logic fail_evt
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          ext_s;
  logic          ext_prev;
  logic          rise;
  logic [CW-1:0] quiet_cnt;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ext_clk),
    .q    (ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= ext_s;
  end

  assign rise     = ext_s & ~ext_prev;
  assign fail_evt = enable & ~rise & (quiet_cnt == LAST);

  // Counts reference cycles since the last seen rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (!enable)          quiet_cnt <= '0;
    else if (rise || fail_evt) quiet_cnt <= '0;
    else                       quiet_cnt <= quiet_cnt + CW'(1);
  end
endmodule

// File: rtl/clkmon_pll_watch.sv
module clkmon_pll_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pll_locked,
  output logic loss_evt
);
  logic lock_s;
  logic lock_prev;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pll_locked),
    .q    (lock_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev <= 1'b0;
    else        lock_prev <= lock_s;
  end

  assign loss_evt = enable & lock_prev & ~lock_s;
endmodule

// File: rtl/clkmon_unlock_win.sv
module clkmon_unlock_win #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock,
  output logic win_open
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (unlock)     left <= CW'(WINDOW);
    else if (left != '0) left <= left - CW'(1);
  end

  assign win_open = (left != '0);
endmodule

// File: rtl/clkmon_ctrl_reg.sv
module clkmon_ctrl_reg
  import clkmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_low,
  input  logic       win_open,
  input  logic       osc_evt,
  input  logic       pll_evt,
  output ctl_t       ctl
);
  logic osc_clr, pll_clr, osc_set, pll_set;

  assign osc_clr = wr_en & wr_low[BIT_OSC_FLAG];
  assign pll_clr = wr_en & wr_low[BIT_PLL_FLAG];
  assign osc_set = wr_en & win_open & wr_low[BIT_OSC_EN];
  assign pll_set = wr_en & win_open & wr_low[BIT_PLL_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      ctl.osc_en   <= en_next(ctl.osc_en, osc_set);
      ctl.pll_en   <= en_next(ctl.pll_en, pll_set);
      ctl.osc_flag <= flag_next(ctl.osc_flag, osc_evt, osc_clr);
      ctl.pll_flag <= flag_next(ctl.pll_flag, pll_evt, pll_clr);
    end
  end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int TIMEOUT     = 32,
  parameter int WINDOW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_clk,
  input  logic       pll_locked,
  input  logic       unlock,
  output logic       nmi
);
  ctl_t ctl;
  logic win_open;
  logic osc_evt;
  logic pll_evt;
  logic wr_rsv_unused;

  assign wr_rsv_unused = ^wr_data[7:4];

  clkmon_unlock_win #(.WINDOW(WINDOW)) u_win (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .unlock  (unlock),
    .win_open(win_open)
  );

  clkmon_osc_watch #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_osc (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .enable  (ctl.osc_en),
    .ext_clk (ext_clk),
    .fail_evt(osc_evt)
  );

  clkmon_pll_watch #(.SYNC_STAGES(SYNC_STAGES)) u_pll (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .enable    (ctl.pll_en),
    .pll_locked(pll_locked),
    .loss_evt  (pll_evt)
  );

  clkmon_ctrl_reg u_reg (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_low  (wr_data[3:0]),
    .win_open(win_open),
    .osc_evt (osc_evt),
    .pll_evt (pll_evt),
    .ctl     (ctl)
  );

  assign rd_data = pack_view(ctl);
  assign nmi     = nmi_of(ctl);
endmodule

// File: rtl/clkmon_checks.sv
module clkmon_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       unlock,
  input logic       nmi,
  input logic       win_open,
  input logic       osc_evt,
  input logic       pll_evt
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0); // R1

  AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> win_open); // R5

  AST_OSC_EN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> $past(win_open && wr_en && wr_data[0])); // R5

  AST_PLL_EN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> $past(win_open && wr_en && wr_data[2])); // R5

  AST_OSC_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |=> rd_data[0]); // R6

  AST_PLL_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] |=> rd_data[2]); // R6

  AST_OSC_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]); // R4

  AST_PLL_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> rd_data[2]); // R2

  AST_OSC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    osc_evt |=> rd_data[1]); // R8

  AST_PLL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pll_evt |=> rd_data[3]); // R8

  AST_OSC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && wr_en && wr_data[1] && !osc_evt) |=> !rd_data[1]); // R3

  AST_PLL_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && wr_en && wr_data[3] && !pll_evt) |=> !rd_data[3]); // R3

  AST_NMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> (rd_data[1] || rd_data[3])); // R9

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !(wr_en && (wr_data[1] || wr_data[3]))) |=> nmi); // R9
endmodule

bind clkmon_top clkmon_checks u_checks (
  .clk     (ref_clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .unlock  (unlock),
  .nmi     (nmi),
  .win_open(win_open),
  .osc_evt (osc_evt),
  .pll_evt (pll_evt)
);

// File: tb/clkmon_top_bench.sv
module clkmon_top_bench;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       ext_clk;
  logic       pll_locked;
  logic       unlock;
  logic       nmi;
  logic       ext_run;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  clkmon_top u_clkmon_top (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ext_clk   (ext_clk),
    .pll_locked(pll_locked),
    .unlock    (unlock),
    .nmi       (nmi)
  );

  always #5 ref_clk = ~ref_clk;

  // External oscillator: 40 ns period while running, frozen otherwise
  initial begin
    ext_clk = 1'b0;
    forever begin
      if (ext_run) #20 ext_clk = ~ext_clk;
      else         #10;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [7:0] exp_reg, logic exp_nmi);
    chk(req, rd_data, exp_reg);
    chk({req, " nmi"}, {7'd0, nmi}, {7'd0, exp_nmi});
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; unlock = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cycles(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // Write sampled on the k-th edge after the edge that samples unlock
  task automatic unlock_write(int k, logic [7:0] d);
    unlock = 1'b1;
    cycles(1);
    unlock = 1'b0;
    cycles(k - 1);
    wr(d);
  endtask

  task automatic t_reset();
    ext_run = 1'b0; pll_locked = 1'b0;
    do_reset();
    chk_state("R7 reset value", 8'h00, 1'b0);
  endtask

  task automatic t_reserved();
    ext_run = 1'b1; pll_locked = 1'b0;
    do_reset();
    unlock_write(1, 8'hF0);
    chk_state("R1 reserved write", 8'h00, 1'b0);
    do_reset();
    unlock_write(1, 8'hFF);
    chk_state("R1 R3 all-ones write", 8'h05, 1'b0);
  endtask

  task automatic t_protection();
    ext_run = 1'b1; pll_locked = 1'b0;
    do_reset();
    wr(8'h05);
    chk_state("R5 unprotected write", 8'h00, 1'b0);
    unlock_write(5, 8'h05);
    chk_state("R5 write after window", 8'h00, 1'b0);
    unlock_write(4, 8'h05);
    chk_state("R5 last window edge", 8'h05, 1'b0);
  endtask

  task automatic t_sticky();
    unlock_write(1, 8'h00);
    chk_state("R6 protected zero write", 8'h05, 1'b0);
    wr(8'h00);
    chk_state("R6 plain zero write", 8'h05, 1'b0);
    do_reset();
    chk_state("R6 reset clears enables", 8'h00, 1'b0);
  endtask

  task automatic t_osc();
    ext_run = 1'b1; pll_locked = 1'b0;
    do_reset();
    unlock_write(2, 8'h01);
    cycles(100);
    chk_state("R4 toggling clock", 8'h01, 1'b0);
    ext_run = 1'b0;
    cycles(20);
    chk_state("R4 before timeout", 8'h01, 1'b0);
    cycles(25);
    chk_state("R4 dead clock", 8'h03, 1'b1);
    wr(8'h02);
    chk_state("R3 osc clear", 8'h01, 1'b0);
    cycles(40);
    chk_state("R4 re-detect", 8'h03, 1'b1);
    do_reset();
    cycles(60);
    chk_state("R4 monitor off", 8'h00, 1'b0);
  endtask

  task automatic t_pll();
    ext_run = 1'b1; pll_locked = 1'b1;
    do_reset();
    unlock_write(1, 8'h04);
    cycles(5);
    pll_locked = 1'b0;
    cycles(5);
    chk_state("R2 lock loss", 8'h0C, 1'b1);
    wr(8'h00);
    chk_state("R3 zero write keeps flag", 8'h0C, 1'b1);
    wr(8'h08);
    chk_state("R3 pll clear", 8'h04, 1'b0);
    // Set-wins: clear write sampled on the same edge the loss sets the flag
    pll_locked = 1'b1;
    cycles(5);
    pll_locked = 1'b0;
    cycles(2);
    wr(8'h08);
    chk_state("R8 set beats clear", 8'h0C, 1'b1);
    do_reset();
    pll_locked = 1'b0;
    cycles(5);
    chk_state("R2 monitor off", 8'h00, 1'b0);
  endtask

  task automatic t_nmi();
    ext_run = 1'b0; pll_locked = 1'b1;
    do_reset();
    unlock_write(1, 8'h05);
    cycles(3);
    pll_locked = 1'b0;
    cycles(40);
    chk_state("R9 both flags", 8'h0F, 1'b1);
    ext_run = 1'b1;
    cycles(10);
    wr(8'h02);
    chk_state("R9 one flag left", 8'h0D, 1'b1);
    wr(8'h08);
    chk_state("R9 all cleared", 8'h05, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ext_run = 1'b0; pll_locked = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; unlock = 1'b0;
    t_reset();
    t_reserved();
    t_protection();
    t_sticky();
    t_osc();
    t_pll();
    t_nmi();
    finish_run();
  end
endmodule